// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Handler

This block services interrupts on a backplane with seven prioritized, active-low request lines. A configuration mask selects the levels this module answers. Among the pending levels that the mask enables, level 7 ranks highest and level 1 ranks lowest. When a served level is pending, the handler asks for the bus through a request/grant pair and waits for a grant.

Once granted, it runs an acknowledge read. It drives the 3-bit code of the winning level onto the low address lines and asserts the acknowledge line and the address strobe. It also asserts the data strobes and the long-word line in the pattern that matches the configured status/ID width.

The interrupter ends the cycle in one of two ways. A transfer acknowledge makes the handler capture the status/ID, zero-extended to the width it asked for, and present it with the level to the local CPU. A bus error aborts the cycle and raises an error flag instead. Either result is held until the CPU acknowledges it.

Top module: `irq_ack_handler`

## Requirements
- R1: After reset, `bus_req`, `vec_valid` and `vec_err` are low, and `iack_n`, `as_n`, `ds0_n`, `ds1_n` and `lword_n` are high.
- R2: A request line that is low while its bit in `serve_mask` is 0 is ignored. `bus_req` stays low and no acknowledge cycle starts.
- R3: The level chosen is the highest numbered level `n` with `irq_n[n]` low and `serve_mask[n]` high. It appears on `vec_level` from the cycle `bus_req` rises.
- R4: `bus_req` rises one cycle after a served level is seen pending. `iack_n` stays high until a cycle after `bus_grant` is sampled high.
- R5: In the acknowledge cycle, `iack_n` and `as_n` are low and `addr` equals the binary level number, zero-extended.
- R6: The strobes follow `id_width` as latched at the start. 2'b00 (8 bits): only `ds0_n` is low. 2'b01 (16 bits): `ds0_n` and `ds1_n` are low. 2'b10 or 2'b11 (32 bits): `ds0_n`, `ds1_n` and `lword_n` are all low.
- R7: `dtack_n` sampled low during the cycle sets `vec_valid` on the next cycle. `vec_id` then holds `data_in` masked to 8, 16 or 32 bits according to the width.
- R8: `berr_n` sampled low during the cycle sets `vec_err` and leaves `vec_valid` low. This holds even when `dtack_n` is low in the same cycle.
- R9: `iack_n`, all strobes and `bus_req` are released on the cycle after termination. No new request is made until `dtack_n` and `berr_n` are both seen high.
- R10: `vec_valid` or `vec_err` stays set, with `vec_id` stable, until `vec_ack` is sampled high. While either is set, no new request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 7 | Request lines, index n = level n, active low |
| serve_mask | input | 7 | Levels this handler serves, index n = level n |
| id_width | input | 2 | Status/ID width: 0 = 8, 1 = 16, 2/3 = 32 bits |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Bus grant from the arbiter |
| addr | output | ADDR_W | Address bus, carries the level code |
| as_n | output | 1 | Address strobe, active low |
| iack_n | output | 1 | Interrupt acknowledge, active low |
| ds0_n | output | 1 | Low data strobe, active low |
| ds1_n | output | 1 | High data strobe, active low |
| lword_n | output | 1 | Long-word select, active low |
| data_in | input | DATA_W | Data bus carrying the status/ID |
| dtack_n | input | 1 | Transfer acknowledge, active low |
| berr_n | input | 1 | Bus error, active low |
| vec_valid | output | 1 | Captured status/ID is ready |
| vec_err | output | 1 | Acknowledge cycle ended in a bus error |
| vec_level | output | 3 | Level being or last serviced |
| vec_id | output | DATA_W | Captured status/ID |
| vec_ack | input | 1 | CPU takes the result, clears valid and error |

## Verification
Transfer acknowledge and bus error can both arrive in the same acknowledge cycle. They lead to opposite outcomes: one presents a vector, the other an error. The bench provokes this by pulling `dtack_n` and `berr_n` low together while the strobes are out. It then expects `vec_err` set and `vec_valid` clear on the next cycle, with the strobes and request released just as for a single termination.

// File: rtl/irq_ack_handler.sv
`timescale 1ns/1ps
module irq_ack_handler #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:1]        irq_n,
  input  logic [7:1]        serve_mask,
  input  logic [1:0]        id_width,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic [ADDR_W-1:0] addr,
  output logic              as_n,
  output logic              iack_n,
  output logic              ds0_n,
  output logic              ds1_n,
  output logic              lword_n,
  input  logic [DATA_W-1:0] data_in,
  input  logic              dtack_n,
  input  logic              berr_n,
  output logic              vec_valid,
  output logic              vec_err,
  output logic [2:0]        vec_level,
  output logic [DATA_W-1:0] vec_id,
  input  logic              vec_ack
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_CYC, S_DONE} st_t;

  st_t              st;
  logic [2:0]       lvl;
  logic [1:0]       wid;
  logic [2:0]       pick_lvl;
  logic [DATA_W-1:0] id_cap;
  logic             cyc;
  logic             bus_quiet;

  always_comb begin
    pick_lvl = 3'd0;
    for (int i = 1; i <= 7; i++)
      if (!irq_n[i] && serve_mask[i]) pick_lvl = 3'(i);
  end

  always_comb begin
    case (wid)
      2'b00:   id_cap = DATA_W'(data_in[7:0]);
      2'b01:   id_cap = DATA_W'(data_in[15:0]);
      default: id_cap = data_in;
    endcase
  end

  assign bus_quiet = dtack_n && berr_n;
  assign cyc       = (st == S_CYC);
  assign bus_req   = (st == S_REQ) || cyc;
  assign iack_n    = !cyc;
  assign as_n      = !cyc;
  assign ds0_n     = !cyc;
  assign ds1_n     = !(cyc && wid != 2'b00);
  assign lword_n   = !(cyc && wid[1]);
  assign addr      = cyc ? ADDR_W'(lvl) : '0;
  assign vec_level = lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      lvl       <= 3'd0;
      wid       <= 2'b00;
      vec_valid <= 1'b0;
      vec_err   <= 1'b0;
      vec_id    <= '0;
    end else begin
      if (vec_ack) begin
        vec_valid <= 1'b0;
        vec_err   <= 1'b0;
      end
      case (st)
        S_IDLE:
          if (pick_lvl != 3'd0 && !vec_valid && !vec_err && bus_quiet) begin
            lvl <= pick_lvl;
            wid <= id_width;
            st  <= S_REQ;
          end
        S_REQ:
          if (bus_grant) st <= S_CYC;
        S_CYC:
          if (!berr_n) begin
            vec_err <= 1'b1;
            st      <= S_DONE;
          end else if (!dtack_n) begin
            vec_valid <= 1'b1;
            vec_id    <= id_cap;
            st        <= S_DONE;
          end
        default:
          if (bus_quiet) st <= S_IDLE;
      endcase
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!bus_req && iack_n && !vec_valid && !vec_err));

  assert_iack_after_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iack_n) |-> $past(bus_grant));

  assert_level_on_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !iack_n |-> (addr[2:0] != 3'd0 && as_n == 1'b0));

  assert_berr_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!iack_n && !berr_n) |=> (vec_err && !vec_valid));

  assert_result_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_valid && vec_err));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!iack_n && !(dtack_n && berr_n)) |=> (iack_n && ds0_n && !bus_req));

  assert_hold_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ack) |=> (vec_valid && $stable(vec_id)));

  assert_no_req_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> (!vec_valid && !vec_err));

endmodule

// File: tb/irq_ack_handler_bench.sv
`timescale 1ns/1ps
module irq_ack_handler_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:1]  irq_n = '1;
  logic [7:1]  serve_mask = '0;
  logic [1:0]  id_width = 2'b00;
  logic        bus_req;
  logic        bus_grant = 1'b0;
  logic [31:0] addr;
  logic        as_n, iack_n, ds0_n, ds1_n, lword_n;
  logic [31:0] data_in = '0;
  logic        dtack_n = 1'b1;
  logic        berr_n = 1'b1;
  logic        vec_valid, vec_err;
  logic [2:0]  vec_level;
  logic [31:0] vec_id;
  logic        vec_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_ack_handler u_irq_ack_handler (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .serve_mask(serve_mask),
    .id_width(id_width), .bus_req(bus_req), .bus_grant(bus_grant),
    .addr(addr), .as_n(as_n), .iack_n(iack_n), .ds0_n(ds0_n),
    .ds1_n(ds1_n), .lword_n(lword_n), .data_in(data_in),
    .dtack_n(dtack_n), .berr_n(berr_n), .vec_valid(vec_valid),
    .vec_err(vec_err), .vec_level(vec_level), .vec_id(vec_id),
    .vec_ack(vec_ack));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  localparam int NV = 6;
  localparam logic [7:1]  T_MASK [NV] = '{7'b1111111, 7'b1111111, 7'b0011111, 7'b0000001, 7'b0100100, 7'b0000100};
  localparam logic [7:1]  T_IRQ  [NV] = '{7'b1011111, 7'b0101010, 7'b0000000, 7'b1111110, 7'b0011011, 7'b0011011};
  localparam logic [1:0]  T_W    [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1};
  localparam logic [31:0] T_D    [NV] = '{32'hA5A51234, 32'hDEADBEEF, 32'h12345678, 32'hCAFEF00D, 32'h000000FF, 32'h80007FFF};
  localparam logic [2:0]  T_LVL  [NV] = '{3'd6, 3'd7, 3'd5, 3'd1, 3'd6, 3'd3};

  // mode 0: dtack, 1: berr, 2: both together
  task automatic run_ack(input logic [7:1] m, input logic [7:1] q, input logic [1:0] w,
                         input logic [31:0] d, input logic [2:0] lv, input int mode);
    logic [31:0] exp_id;
    exp_id = (w == 2'b00) ? (d & 32'hFF) : (w == 2'b01) ? (d & 32'hFFFF) : d;
    @(negedge clk);
    serve_mask = m; irq_n = q; id_width = w;
    @(negedge clk);
    chk(bus_req == 1'b1, "R4 bus_req raised", 32'(bus_req), 32'd1);
    chk(vec_level == lv, "R3 level choice", 32'(vec_level), 32'(lv));
    @(negedge clk);
    chk(iack_n == 1'b1, "R4 no iack before grant", 32'(iack_n), 32'd1);
    bus_grant = 1'b1;
    @(negedge clk);
    chk(!iack_n && !as_n && addr == 32'(lv), "R5 level on addr", addr, 32'(lv));
    chk({ds0_n, ds1_n, lword_n} == {1'b0, (w == 2'b00), !w[1]}, "R6 strobe pattern",
        32'({ds0_n, ds1_n, lword_n}), 32'({1'b0, (w == 2'b00), !w[1]}));
    data_in = d;
    if (mode != 1) dtack_n = 1'b0;
    if (mode != 0) berr_n = 1'b0;
    @(negedge clk);
    bus_grant = 1'b0;
    chk(iack_n && ds0_n && ds1_n && lword_n && as_n && !bus_req, "R9 release",
        32'({iack_n, ds0_n, ds1_n, lword_n, as_n, bus_req}), 32'b111110);
    if (mode == 0) begin
      chk(vec_valid && !vec_err, "R7 vector valid", 32'({vec_valid, vec_err}), 32'b10);
      chk(vec_id == exp_id, "R7 captured id", vec_id, exp_id);
    end else
      chk(vec_err && !vec_valid, "R8 error not vector", 32'({vec_valid, vec_err}), 32'b01);
    @(negedge clk);
    chk((vec_valid | vec_err) == 1'b1, "R10 result held", 32'({vec_valid, vec_err}), 32'd1);
    vec_ack = 1'b1;
    @(negedge clk);
    vec_ack = 1'b0;
    chk(!vec_valid && !vec_err, "R10 cleared by ack", 32'({vec_valid, vec_err}), 32'd0);
    chk(!bus_req, "R9 wait for quiet bus", 32'(bus_req), 32'd0);
    dtack_n = 1'b1; berr_n = 1'b1;
    @(negedge clk);
    irq_n = '1;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_req && iack_n && as_n && ds0_n && ds1_n && lword_n && !vec_valid && !vec_err,
        "R1 reset state", 32'({bus_req, iack_n, vec_valid, vec_err}), 32'b0100);
    rst_n = 1'b1;

    // R2: unserved levels pending
    serve_mask = 7'b0000001; irq_n = 7'b0000001;
    repeat (3) begin
      @(negedge clk);
      chk(!bus_req && iack_n, "R2 unserved ignored", 32'(bus_req), 32'd0);
    end
    irq_n = '1;

    for (int k = 0; k < NV; k++)
      run_ack(T_MASK[k], T_IRQ[k], T_W[k], T_D[k], T_LVL[k], 0);

    run_ack(7'b1111111, 7'b1110111, 2'd2, 32'h11112222, 3'd4, 1);  // R8 bus error alone
    run_ack(7'b1111111, 7'b1111101, 2'd0, 32'h33333344, 3'd2, 2);  // R8 both same cycle

    // R10: pending result blocks a new request
    @(negedge clk);
    serve_mask = 7'b1111111; irq_n = 7'b1111011; id_width = 2'b00;
    @(negedge clk);
    bus_grant = 1'b1;
    @(negedge clk);
    data_in = 32'h00000055; dtack_n = 1'b0;
    @(negedge clk);
    dtack_n = 1'b1; bus_grant = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(!bus_req && vec_valid && vec_id == 32'h55, "R10 blocked while pending",
          32'({bus_req, vec_valid}), 32'b01);
    end
    vec_ack = 1'b1;
    @(negedge clk);
    vec_ack = 1'b0;
    @(negedge clk);
    chk(bus_req == 1'b1, "R10 resumes after ack", 32'(bus_req), 32'd1);
    bus_grant = 1'b1;
    @(negedge clk);
    dtack_n = 1'b0;
    @(negedge clk);
    dtack_n = 1'b1; bus_grant = 1'b0; irq_n = '1; vec_ack = 1'b1;
    @(negedge clk);
    vec_ack = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule